// File: doc/BRIEF.md
# Dual Handshake Mailbox Pair

Two 32-bit mailboxes move messages between a host processor and a signal processor. One box carries traffic from the signal processor to the host and the other carries traffic the opposite way. Each box is reached as two 16-bit halves on a small register port. Bit 15 of the high half is a "mail pending" flag.

A sender writes the high half first, then the low half. Writing the low half commits the message and raises the flag. A receiver may read the high half and test the flag as often as it likes. It then reads the low half, which returns the low word and drops the flag. The high half therefore carries only 15 payload bits.

Each box has a 32-bit peek output that shows its current contents without touching the flag. Each box also has a registered pending output that can be polled or used to raise an interrupt.

Top module: `mail_pair`

## Requirements
- R1: After reset, all four half-words read zero, both peek outputs are zero and both pending outputs are 0.
- R2: A write to a high half stores bits 14:0 of the written value and clears bit 15, whatever the flag was before. The result is visible from the next clock edge.
- R3: A write to a low half stores all 16 bits and sets bit 15 of that box's high half at the same clock edge.
- R4: A read of a low half returns the stored low word during the read cycle. It clears bit 15 of that box's high half at the clock edge of the read strobe.
- R5: A read of a high half returns the full high word, including the flag in bit 15, and changes no stored state.
- R6: The peek output of each box shows the high word in bits 31:16 and the low word in bits 15:0. Holding or watching it never changes the flag.
- R7: The two boxes are independent. A select value's bit 1 picks the box (0 = processor-to-host box, peek0/pending[0]; 1 = host-to-processor box, peek1/pending[1]). Bit 0 picks the half (1 = high, 0 = low). An access to one box never alters the other.
- R8: When a low-half write and a low-half read hit the same box in the same cycle, the read returns the old low word. The write's data is stored and the flag ends up set.
- R9: Each pending output equals bit 15 of its box's stored high word and changes only on a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one half-word per cycle |
| wrSel | input | 2 | Write target: bit 1 box, bit 0 half (1 = high) |
| wrData | input | 16 | Write data |
| rdEn | input | 1 | Read strobe; side effects apply only when set |
| rdSel | input | 2 | Read target: bit 1 box, bit 0 half (1 = high) |
| rdData | output | 16 | Combinational read data for rdSel |
| peek0 | output | 32 | Contents of box 0, high word in the upper half |
| peek1 | output | 32 | Contents of box 1, high word in the upper half |
| pending | output | 2 | Flag of each box, bit index = box |

## Verification
On every cycle, the assertions check how the flag responds to the strobes: low writes set it, unopposed low reads clear it, and high writes mask the payload and clear it. They also check that a cycle without a write or a low read leaves both words untouched, and that at most one half-word strobe fires per cycle. Some behaviour only the bench scenarios can show: the actual values returned on reads, the separation between the two boxes over a message exchange, the write-wins collision result, and the return to zero after a reset in mid-run.

// File: rtl/mail_pkg.sv
package mail_pkg;
  localparam int HALF_W  = 16;
  localparam int NUM_BOX = 2;

  typedef struct packed {
    logic wrHi;
    logic wrLo;
    logic rdLo;
  } mbxStrobe_t;
endpackage

// File: rtl/mail_ctrl.sv
module mail_ctrl
  import mail_pkg::*;
#(
  parameter int NBOX = NUM_BOX
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [1:0]                  wrSel,
  input  logic                        rdEn,
  input  logic [1:0]                  rdSel,
  output mbxStrobe_t [NBOX-1:0]       strb
);
  genvar b;
  generate
    for (b = 0; b < NBOX; b++) begin : g_dec
      always_comb begin
        strb[b].wrHi = wrEn && (wrSel[1] == b[0]) &&  wrSel[0];
        strb[b].wrLo = wrEn && (wrSel[1] == b[0]) && !wrSel[0];
        strb[b].rdLo = rdEn && (rdSel[1] == b[0]) && !rdSel[0];
      end
    end
  endgenerate

  logic [2*NBOX-1:0] wrStrobes;
  always_comb begin
    for (int i = 0; i < NBOX; i++) begin
      wrStrobes[2*i]   = strb[i].wrHi;
      wrStrobes[2*i+1] = strb[i].wrLo;
    end
  end

  // R7
  one_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrStrobes));
endmodule

// File: rtl/mail_dpath.sv
module mail_dpath
  import mail_pkg::*;
#(
  parameter int W    = HALF_W,
  parameter int NBOX = NUM_BOX
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  mbxStrobe_t [NBOX-1:0]   strb,
  input  logic [W-1:0]            wrData,
  input  logic [1:0]              rdSel,
  output logic [W-1:0]            rdData,
  output logic [NBOX-1:0][2*W-1:0] peekAll,
  output logic [NBOX-1:0]         pendAll
);
  localparam int FLAG = W - 1;

  logic [NBOX-1:0][W-1:0] hiWord;
  logic [NBOX-1:0][W-1:0] loWord;

  genvar b;
  generate
    for (b = 0; b < NBOX; b++) begin : g_box
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          hiWord[b] <= '0;
          loWord[b] <= '0;
        end else begin
          if (strb[b].wrHi) begin
            hiWord[b] <= {1'b0, wrData[FLAG-1:0]};
          end else if (strb[b].wrLo) begin
            loWord[b]       <= wrData;
            hiWord[b][FLAG] <= 1'b1;
          end else if (strb[b].rdLo) begin
            hiWord[b][FLAG] <= 1'b0;
          end
        end
      end

      assign peekAll[b] = {hiWord[b], loWord[b]};
      assign pendAll[b] = hiWord[b][FLAG];

      // R3
      lo_write_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb[b].wrLo |=> (pendAll[b] && loWord[b] == $past(wrData)));
      // R4
      lo_read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
        (strb[b].rdLo && !strb[b].wrLo) |=> !pendAll[b]);
      // R2
      hi_write_masks_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb[b].wrHi |=> (hiWord[b] == {1'b0, $past(wrData[FLAG-1:0])}));
      // R5
      idle_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
        !(strb[b].wrHi || strb[b].wrLo || strb[b].rdLo) |=>
          ($stable(hiWord[b]) && $stable(loWord[b])));
      // R8
      collide_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
        (strb[b].wrLo && strb[b].rdLo) |=> pendAll[b]);
    end
  endgenerate

  always_comb begin
    if (rdSel[0]) rdData = hiWord[rdSel[1]];
    else          rdData = loWord[rdSel[1]];
  end
endmodule

// File: rtl/mail_pair.sv
module mail_pair
  import mail_pkg::*;
#(
  parameter int W = HALF_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrEn,
  input  logic [1:0]     wrSel,
  input  logic [W-1:0]   wrData,
  input  logic           rdEn,
  input  logic [1:0]     rdSel,
  output logic [W-1:0]   rdData,
  output logic [2*W-1:0] peek0,
  output logic [2*W-1:0] peek1,
  output logic [1:0]     pending
);
  mbxStrobe_t [NUM_BOX-1:0]         strb;
  logic [NUM_BOX-1:0][2*W-1:0]      peekAll;

  mail_ctrl #(.NBOX(NUM_BOX)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrSel (wrSel),
    .rdEn  (rdEn),
    .rdSel (rdSel),
    .strb  (strb)
  );

  mail_dpath #(.W(W), .NBOX(NUM_BOX)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .rdSel   (rdSel),
    .rdData  (rdData),
    .peekAll (peekAll),
    .pendAll (pending)
  );

  assign peek0 = peekAll[0];
  assign peek1 = peekAll[1];
endmodule

// File: tb/mail_pair_test.sv
`timescale 1ns/1ps
module mail_pair_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [15:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [1:0]  rdSel = '0;
  logic [15:0] rdData;
  logic [31:0] peek0, peek1;
  logic [1:0]  pending;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mail_pair uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdEn(rdEn), .rdSel(rdSel), .rdData(rdData), .peek0(peek0),
    .peek1(peek1), .pending(pending)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  ws;
    logic [15:0] wd;
    logic        re;
    logic [1:0]  rs;
    logic [15:0] expRd;
    logic [1:0]  expPend;
    logic [31:0] expPk0;
    logic [31:0] expPk1;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    // R2: high write of box 0 masks bit 15
    '{1'b1, 2'd1, 16'hFFFF, 1'b0, 2'd0, 16'h0000, 2'b00, 32'h7FFF0000, 32'h0},
    // R3 commit on low write; R5 high read sees flag clear
    '{1'b1, 2'd0, 16'h1234, 1'b1, 2'd1, 16'h7FFF, 2'b01, 32'hFFFF1234, 32'h0},
    // R5 high read shows flag, no side effect
    '{1'b0, 2'd0, 16'h0000, 1'b1, 2'd1, 16'hFFFF, 2'b01, 32'hFFFF1234, 32'h0},
    // R4 low read clears box 0; R7 box 1 high write independent
    '{1'b1, 2'd3, 16'h8ABC, 1'b1, 2'd0, 16'h1234, 2'b00, 32'h7FFF1234, 32'h0ABC0000},
    // R3 box 1 commit
    '{1'b1, 2'd2, 16'h5678, 1'b0, 2'd0, 16'h0000, 2'b10, 32'h7FFF1234, 32'h8ABC5678},
    // R8 collision: old word read, write wins
    '{1'b1, 2'd2, 16'h9999, 1'b1, 2'd2, 16'h5678, 2'b10, 32'h7FFF1234, 32'h8ABC9999},
    // R4 box 1 consumed
    '{1'b0, 2'd0, 16'h0000, 1'b1, 2'd2, 16'h9999, 2'b00, 32'h7FFF1234, 32'h0ABC9999},
    // R4 second read keeps flag clear
    '{1'b0, 2'd0, 16'h0000, 1'b1, 2'd2, 16'h9999, 2'b00, 32'h7FFF1234, 32'h0ABC9999},
    // R3 low write of zero still sets flag
    '{1'b1, 2'd0, 16'h0000, 1'b0, 2'd0, 16'h0000, 2'b01, 32'hFFFF0000, 32'h0ABC9999},
    // R2 high write drops pending flag
    '{1'b1, 2'd1, 16'h0001, 1'b1, 2'd3, 16'h0ABC, 2'b00, 32'h00010000, 32'h0ABC9999}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic check_zero(input string tag);
    check(tag, {30'b0, pending}, 32'h0);
    check(tag, peek0, 32'h0);
    check(tag, peek1, 32'h0);
    for (int s = 0; s < 4; s++) begin
      rdSel = s[1:0];
      #0.1;
      check(tag, {16'h0, rdData}, 32'h0);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state while held
    check_zero("R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    check_zero("R1 after release");

    for (int v = 0; v < NV; v++) begin
      wrEn = VECS[v].we; wrSel = VECS[v].ws; wrData = VECS[v].wd;
      rdEn = VECS[v].re; rdSel = VECS[v].rs;
      #1;
      if (VECS[v].re) check($sformatf("vec %0d read", v), {16'h0, rdData}, {16'h0, VECS[v].expRd});
      @(posedge clk);
      @(negedge clk);
      idle();
      check($sformatf("vec %0d pending", v), {30'b0, pending}, {30'b0, VECS[v].expPend});
      check($sformatf("vec %0d peek0", v), peek0, VECS[v].expPk0);
      check($sformatf("vec %0d peek1", v), peek1, VECS[v].expPk1);
    end

    // R6 / R9: commit box 1, then watch peek and pending over idle cycles
    wrEn = 1'b1; wrSel = 2'd2; wrData = 16'hCAFE;
    @(posedge clk); @(negedge clk); idle();
    for (int k = 0; k < 3; k++) begin
      check("R6 peek stable while idle", peek1, 32'h8ABCCAFE);
      check("R9 pending tracks bit 15", {30'b0, pending}, {30'b0, peek1[31], peek0[31]});
      @(negedge clk);
    end
    // R9 pending not changed before the edge by a low read
    rdEn = 1'b1; rdSel = 2'd2;
    #1;
    check("R9 pending holds before edge", {30'b0, pending}, 32'h2);
    check("R4 low read data", {16'h0, rdData}, 32'h0000CAFE);
    @(posedge clk); @(negedge clk); idle();
    check("R9 pending after read edge", {30'b0, pending}, 32'h0);
    check("R7 box 0 untouched", peek0, 32'h00010000);

    // R1 reset in mid-run after loading both boxes
    wrEn = 1'b1; wrSel = 2'd0; wrData = 16'h4444;
    @(posedge clk); @(negedge clk);
    wrSel = 2'd2; wrData = 16'h5555;
    @(posedge clk); @(negedge clk); idle();
    check("R1 preload pending", {30'b0, pending}, 32'h3);
    rstN = 1'b0;
    #1;
    check_zero("R1 mid-run reset");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule